// File: doc/BRIEF.md
# Packed Lane Writeback and Operand Router

This block sits between a 512-bit vector register file and an external per-lane arithmetic datapath for a packed operation on eight 64-bit lanes. It takes the two source vectors and the old destination. It also takes the encoding class, the vector length, a per-lane write mask, and flags for zeroing, broadcast and a memory operand. From these it presents one operand pair per lane to the datapath. It then takes back a result and six exception flags for each lane.

The new destination is built lane by lane. A lane either takes its result, keeps its old value, or is cleared, depending on three things: the encoding class, the lane's position against the active length, and the mask and zeroing controls. The exception flags are ORed over the lanes that actually write a result. For the register form at full length, the broadcast flag is turned into a rounding-override request to the datapath. The new destination and the accumulated flags are registered and come out one cycle after the input strobe.

Top module: `lane_writeback_unit`

## Requirements
- R1: `vecLen` sets the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes; lane i is active when i is below that count.
- R2: With `encClass`=0 (legacy), lanes 0 and 1 take their results and lanes 2 to 7 keep `oldDest`; `vecLen`, `writeMask` and `zeroing` have no effect.
- R3: With `encClass`=1 (VEX), every active lane takes its result and every inactive lane becomes zero; `writeMask` and `zeroing` have no effect.
- R4: With `encClass`=2 or 3 (EVEX), an active lane with its `writeMask` bit at 1 takes its result. An active lane with its mask bit at 0 and `zeroing`=0 keeps `oldDest`.
- R5: In EVEX, an active lane with its mask bit at 0 and `zeroing`=1 becomes zero.
- R6: In EVEX, every inactive lane becomes zero, whatever the mask holds.
- R7: `laneOpA` lane i is always `srcA` lane i. `laneOpB` lane i is `srcB` lane 0 when EVEX, `memOperand`=1 and `broadcast`=1 all hold; otherwise it is `srcB` lane i. Lane i occupies bits [64i+63:64i].
- R8: `roundOverride` is 1 only when EVEX, `memOperand`=0, `broadcast`=1 and 8 active lanes all hold. At that time `roundCtl` equals `rcField`; otherwise both outputs are 0.
- R9: `accFlags` is the OR of `laneFlags[6i+5:6i]` over the lanes that take a result. The flag bits are: 0 invalid, 1 denormal operand, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact.
- R10: After reset `outValid`, `newDest` and `accFlags` are 0. `outValid` is high exactly in the cycle after an `inValid` cycle, and `newDest` and `accFlags` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| encClass | input | 2 | 0 legacy, 1 VEX, 2 or 3 EVEX |
| vecLen | input | 2 | 0: 128 bit, 1: 256 bit, 2 or 3: 512 bit |
| writeMask | input | 8 | Per-lane write enable (EVEX only) |
| zeroing | input | 1 | Clear masked-off lanes instead of merging |
| broadcast | input | 1 | Broadcast (memory form) or rounding override (register form) |
| memOperand | input | 1 | Second source comes from memory |
| rcField | input | 2 | Rounding-control value for the override |
| oldDest | input | 512 | Previous destination contents |
| srcA | input | 512 | First source vector |
| srcB | input | 512 | Second source vector |
| laneOpA | output | 512 | First operand per lane to the datapath |
| laneOpB | output | 512 | Second operand per lane to the datapath |
| roundOverride | output | 1 | Rounding override request to the datapath |
| roundCtl | output | 2 | Rounding control for the override |
| laneResult | input | 512 | Per-lane results from the datapath |
| laneFlags | input | 48 | Six exception flags per lane from the datapath |
| outValid | output | 1 | New destination is valid |
| newDest | output | 512 | Written-back destination |
| accFlags | output | 6 | Accumulated exception flags |

## Verification
The hardest cases to reach are the ones where two rules could both claim a lane. One is an EVEX lane that has its mask bit set but lies above the active length, which must still be cleared. Another is broadcast with the memory flag, where only the datapath results show whether lane 0 of the second source reached every lane. The stimulus sweeps every encoding class, length, zeroing, broadcast and memory setting against masks chosen to straddle each length boundary, with fresh random data each time. The bench's own lane model turns the routed operands into results and flags, so a misrouted operand changes the written lane.

// File: rtl/lane_wb_pkg.sv
package lane_wb_pkg;
  parameter int NUM_LANES   = 8;
  parameter int LEGACY_LANES = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_LANES-1:0] take;   // lane writes its result
    logic [NUM_LANES-1:0] clear;  // lane is forced to zero
    logic                 bcast;  // route srcB lane 0 to every lane
    logic                 load;   // capture a new destination
  } wbStrobe_t;
endpackage

// File: rtl/lane_wb_ctrl.sv
module lane_wb_ctrl
  import lane_wb_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic             inValid,
  input  logic [1:0]       encClass,
  input  logic [1:0]       vecLen,
  input  logic [LANES-1:0] writeMask,
  input  logic             zeroing,
  input  logic             broadcast,
  input  logic             memOperand,
  input  logic [1:0]       rcField,
  output wbStrobe_t        strobe,
  output logic             roundOverride,
  output logic [1:0]       roundCtl
);
  localparam int CNT_W = $clog2(LANES) + 1;

  logic [CNT_W-1:0] activeCnt;
  logic isLegacy, isVex, isEvex, fullLen;

  always_comb begin
    case (vecLen)
      2'd0:    activeCnt = CNT_W'(2);
      2'd1:    activeCnt = CNT_W'(4);
      default: activeCnt = CNT_W'(LANES);
    endcase
  end

  assign isLegacy = (encClass == 2'd0);
  assign isVex    = (encClass == 2'd1);
  assign isEvex   = encClass[1];
  assign fullLen  = (activeCnt == CNT_W'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneActive;
    assign laneActive = (CNT_W'(i) < activeCnt);
    always_comb begin
      strobe.take[i]  = 1'b0;
      strobe.clear[i] = 1'b0;
      if (isLegacy) begin
        strobe.take[i] = (i < LEGACY_LANES);
      end else if (isVex) begin
        strobe.take[i]  = laneActive;
        strobe.clear[i] = !laneActive;
      end else begin
        strobe.take[i]  = laneActive && writeMask[i];
        strobe.clear[i] = !laneActive || (!writeMask[i] && zeroing);
      end
    end
  end

  assign strobe.bcast  = isEvex && memOperand && broadcast;
  assign strobe.load   = inValid;
  assign roundOverride = isEvex && !memOperand && broadcast && fullLen;
  assign roundCtl      = roundOverride ? rcField : 2'b00;
endmodule

// File: rtl/lane_wb_datapath.sv
module lane_wb_datapath
  import lane_wb_pkg::*;
#(
  parameter int LANES  = NUM_LANES,
  parameter int LANE_W = 64,
  parameter int FLAG_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wbStrobe_t               strobe,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] oldDest,
  input  logic [LANES*LANE_W-1:0] laneResult,
  input  logic [LANES*FLAG_W-1:0] laneFlags,
  output logic [LANES*LANE_W-1:0] laneOpA,
  output logic [LANES*LANE_W-1:0] laneOpB,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] newDest,
  output logic [FLAG_W-1:0]       accFlags
);
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0]  nextDest;
  logic [FLAG_W-1:0] nextFlags;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneOpA[i*LANE_W +: LANE_W] = srcA[i*LANE_W +: LANE_W];
    assign laneOpB[i*LANE_W +: LANE_W] = strobe.bcast ? srcB[LANE_W-1:0]
                                                      : srcB[i*LANE_W +: LANE_W];
    always_comb begin
      if (strobe.take[i])       nextDest[i*LANE_W +: LANE_W] = laneResult[i*LANE_W +: LANE_W];
      else if (strobe.clear[i]) nextDest[i*LANE_W +: LANE_W] = '0;
      else                      nextDest[i*LANE_W +: LANE_W] = oldDest[i*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    nextFlags = '0;
    for (int i = 0; i < LANES; i++)
      if (strobe.take[i]) nextFlags = nextFlags | laneFlags[i*FLAG_W +: FLAG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      newDest  <= '0;
      accFlags <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        newDest  <= nextDest;
        accFlags <= nextFlags;
      end
    end
  end
endmodule

// File: rtl/lane_writeback_unit.sv
module lane_writeback_unit
  import lane_wb_pkg::*;
#(
  parameter int LANES  = NUM_LANES,
  parameter int LANE_W = 64,
  parameter int FLAG_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [1:0]              encClass,
  input  logic [1:0]              vecLen,
  input  logic [LANES-1:0]        writeMask,
  input  logic                    zeroing,
  input  logic                    broadcast,
  input  logic                    memOperand,
  input  logic [1:0]              rcField,
  input  logic [LANES*LANE_W-1:0] oldDest,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  output logic [LANES*LANE_W-1:0] laneOpA,
  output logic [LANES*LANE_W-1:0] laneOpB,
  output logic                    roundOverride,
  output logic [1:0]              roundCtl,
  input  logic [LANES*LANE_W-1:0] laneResult,
  input  logic [LANES*FLAG_W-1:0] laneFlags,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] newDest,
  output logic [FLAG_W-1:0]       accFlags
);
  wbStrobe_t strobe;

  lane_wb_ctrl #(.LANES(LANES)) u_ctrl (
    .inValid(inValid), .encClass(encClass), .vecLen(vecLen),
    .writeMask(writeMask), .zeroing(zeroing), .broadcast(broadcast),
    .memOperand(memOperand), .rcField(rcField), .strobe(strobe),
    .roundOverride(roundOverride), .roundCtl(roundCtl)
  );

  lane_wb_datapath #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .oldDest(oldDest), .laneResult(laneResult), .laneFlags(laneFlags),
    .laneOpA(laneOpA), .laneOpB(laneOpB), .outValid(outValid),
    .newDest(newDest), .accFlags(accFlags)
  );
endmodule

// File: rtl/lane_wb_checker.sv
module lane_wb_checker #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int FLAG_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inValid,
  input logic [1:0]              encClass,
  input logic [1:0]              vecLen,
  input logic [LANES-1:0]        writeMask,
  input logic                    broadcast,
  input logic                    memOperand,
  input logic [LANES*LANE_W-1:0] oldDest,
  input logic [LANES*LANE_W-1:0] srcB,
  input logic [LANES*LANE_W-1:0] laneOpB,
  input logic                    roundOverride,
  input logic                    outValid,
  input logic [LANES*LANE_W-1:0] newDest,
  input logic [FLAG_W-1:0]       accFlags
);
  localparam int VEC_W = LANES * LANE_W;

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_legacy_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && encClass == 2'd0) |=>
      newDest[VEC_W-1:2*LANE_W] == $past(oldDest[VEC_W-1:2*LANE_W]));
  p_vex_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && encClass == 2'd1 && vecLen == 2'd0) |=>
      newDest[VEC_W-1:2*LANE_W] == '0);
  p_evex_nomask_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && encClass[1] && writeMask == '0) |=> accFlags == '0);
  p_round_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    roundOverride |-> (encClass[1] && !memOperand && broadcast && vecLen[1]));
  p_bcast_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (encClass[1] && memOperand && broadcast) |-> laneOpB == {LANES{srcB[LANE_W-1:0]}});
endmodule

bind lane_writeback_unit lane_wb_checker #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .encClass(encClass), .vecLen(vecLen),
  .writeMask(writeMask), .broadcast(broadcast), .memOperand(memOperand),
  .oldDest(oldDest), .srcB(srcB), .laneOpB(laneOpB), .roundOverride(roundOverride),
  .outValid(outValid), .newDest(newDest), .accFlags(accFlags)
);

// File: tb/lane_writeback_unit_tb.sv
module lane_writeback_unit_tb;
  localparam int L = 8;
  localparam int W = 64;
  localparam int F = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] encClass = '0, vecLen = '0, rcField = '0;
  logic [L-1:0] writeMask = '0;
  logic zeroing = 1'b0, broadcast = 1'b0, memOperand = 1'b0;
  logic [L*W-1:0] oldDest = '0, srcA = '0, srcB = '0;
  logic [L*W-1:0] laneOpA, laneOpB, laneResult, newDest;
  logic [L*F-1:0] laneFlags;
  logic roundOverride, outValid;
  logic [1:0] roundCtl;
  logic [F-1:0] accFlags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lane_writeback_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .encClass(encClass), .vecLen(vecLen),
    .writeMask(writeMask), .zeroing(zeroing), .broadcast(broadcast), .memOperand(memOperand),
    .rcField(rcField), .oldDest(oldDest), .srcA(srcA), .srcB(srcB),
    .laneOpA(laneOpA), .laneOpB(laneOpB), .roundOverride(roundOverride), .roundCtl(roundCtl),
    .laneResult(laneResult), .laneFlags(laneFlags), .outValid(outValid),
    .newDest(newDest), .accFlags(accFlags)
  );

  // bench model of the external lane datapath
  function automatic logic [W-1:0] laneFn(logic [W-1:0] a, logic [W-1:0] b);
    return (a ^ {b[31:0], b[63:32]}) + 64'h0123_4567_89AB_CDEF;
  endfunction
  function automatic logic [F-1:0] flagFn(logic [W-1:0] a, logic [W-1:0] b);
    return (a[5:0] ^ b[13:8]) & {a[40], b[41], a[42], b[43], a[44], b[45]};
  endfunction

  always_comb begin
    for (int i = 0; i < L; i++) begin
      laneResult[i*W +: W] = laneFn(laneOpA[i*W +: W], laneOpB[i*W +: W]);
      laneFlags[i*F +: F]  = flagFn(laneOpA[i*W +: W], laneOpB[i*W +: W]);
    end
  end

  typedef struct {
    logic [L*W-1:0] dest;
    logic [F-1:0]   flags;
    int             tag [L];
  } exp_t;
  exp_t expQ[$];
  logic [L*W-1:0] lastDest = '0;

  function automatic string tagName(int t);
    case (t)
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      13: return "R1/R3";
      16: return "R1/R6";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [L*W-1:0] rand512();
    logic [L*W-1:0] v;
    for (int k = 0; k < L*W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [L*W-1:0] act, logic [L*W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: applies one operation and queues its expected outcome
  task automatic drive(logic [1:0] enc, logic [1:0] len, logic [L-1:0] msk,
                       logic z, logic bc, logic mem);
    exp_t e;
    int act;
    logic [L*W-1:0] expOpB;
    logic expOvr;
    @(negedge clk);
    encClass = enc; vecLen = len; writeMask = msk; zeroing = z;
    broadcast = bc; memOperand = mem; rcField = 2'($urandom);
    srcA = rand512(); srcB = rand512(); oldDest = rand512();
    inValid = 1'b1;
    act = (len == 2'd0) ? 2 : (len == 2'd1) ? 4 : 8;
    e.flags = '0;
    for (int i = 0; i < L; i++) begin
      logic [W-1:0] bSel, res, old;
      logic take;
      bSel = (enc[1] && mem && bc) ? srcB[W-1:0] : srcB[i*W +: W];
      expOpB[i*W +: W] = bSel;
      res = laneFn(srcA[i*W +: W], bSel);
      old = oldDest[i*W +: W];
      take = 1'b0;
      if (enc == 2'd0) begin
        take = (i < 2);
        e.dest[i*W +: W] = take ? res : old;
        e.tag[i] = 2;
      end else if (enc == 2'd1) begin
        take = (i < act);
        e.dest[i*W +: W] = take ? res : '0;
        e.tag[i] = take ? 3 : 13;
      end else if (i >= act) begin
        e.dest[i*W +: W] = '0;
        e.tag[i] = 16;
      end else begin
        take = msk[i];
        e.dest[i*W +: W] = take ? res : (z ? '0 : old);
        e.tag[i] = (!take && z) ? 5 : 4;
      end
      if (take) e.flags = e.flags | flagFn(srcA[i*W +: W], bSel);
    end
    expQ.push_back(e);
    expOvr = enc[1] && !mem && bc && (act == 8);
    #2;
    check(laneOpB == expOpB, "R7", "laneOpB", laneOpB, expOpB);
    check(laneOpA == srcA, "R7", "laneOpA", laneOpA, srcA);
    check(roundOverride == expOvr, "R8", "roundOverride",
          {{(L*W-1){1'b0}}, roundOverride}, {{(L*W-1){1'b0}}, expOvr});
    check(roundCtl == (expOvr ? rcField : 2'b00), "R8", "roundCtl",
          {{(L*W-2){1'b0}}, roundCtl}, {{(L*W-2){1'b0}}, (expOvr ? rcField : 2'b00)});
  endtask

  // monitor: pops and compares each produced result
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected outValid", '0, '0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        for (int i = 0; i < L; i++)
          check(newDest[i*W +: W] == e.dest[i*W +: W], tagName(e.tag[i]),
                $sformatf("lane %0d", i),
                {{(L*W-W){1'b0}}, newDest[i*W +: W]}, {{(L*W-W){1'b0}}, e.dest[i*W +: W]});
        check(accFlags == e.flags, "R9", "accFlags",
              {{(L*W-F){1'b0}}, accFlags}, {{(L*W-F){1'b0}}, e.flags});
        lastDest = e.dest;
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] masks [7];
    masks = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h0C};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(outValid == 1'b0, "R10", "reset outValid", {{(L*W-1){1'b0}}, outValid}, '0);
    check(newDest == '0, "R10", "reset newDest", newDest, '0);
    check(accFlags == '0, "R10", "reset accFlags", {{(L*W-F){1'b0}}, accFlags}, '0);

    for (int enc = 0; enc < 4; enc++)
      for (int len = 0; len < 4; len++)
        for (int m = 0; m < 7; m++)
          for (int opt = 0; opt < 8; opt++)
            drive(2'(enc), 2'(len), masks[m], opt[0], opt[1], opt[2]);
    for (int n = 0; n < 200; n++)
      drive(2'($urandom), 2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

    @(negedge clk);
    inValid = 1'b0;
    oldDest = rand512(); srcA = rand512(); srcB = rand512();
    repeat (4) @(negedge clk);
    // R10 hold while idle
    check(outValid == 1'b0, "R10", "idle outValid", {{(L*W-1){1'b0}}, outValid}, '0);
    check(newDest == lastDest, "R10", "idle hold newDest", newDest, lastDest);
    check(expQ.size() == 0, "R10", "missing outputs",
          {{(L*W-32){1'b0}}, 32'(expQ.size())}, '0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule